// File: doc/BRIEF.md
# ACPI Sleep-State Rail Sequencer

This block is the digital control core of a multi-rail power controller for a desktop memory and chipset supply. It reads the system sleep inputs (a chip enable that acts as the S5 signal and an S3 signal that is low in suspend), a main-5V-good comparator and a supply-ready comparator. From these it drives the enables for the memory buck regulator, the termination tracking LDO, the 1.2V LDO and the standby 3.3V LDO. It also drives the two gate controls for the dual 5V/3.3V rails and the charge and discharge commands for the soft-start capacitor.

Progress through a power-up is gated by three digitised soft-start thresholds at 1.5 V, 2.0 V and 2.5 V. The buck counts as stable once the ramp passes 1.5 V. The two LDOs start only after the ramp passes 2.5 V. On entry to suspend the ramp is pulled back to 2.0 V. After the supply becomes ready, the inputs are ignored for a parameterised period and then for a second settling period, while the soft-start capacitor drains. The chip enable and S3 inputs are resynchronised by two flops. The comparator flags are taken as already synchronous. All outputs are registered.

Top module: `acpi_rail_seq`

## Requirements
- R1: While reset is high or `supply_ok_i` is low, every rail enable and gate control is low, `ss_charge_o` is low and `ss_discharge_o` is high.
- R2: After `supply_ok_i` rises, the buck stays off with the standby 3.3V LDO on and soft-start discharging for exactly IGNORE_CYC + SETTLE_CYC cycles plus the one cycle of S5 evaluation, whatever the sleep inputs are.
- R3: In S5 (synchronised enable low) only `sb33_en_o` is on; `dual_main_en_o` and `sb5_gate_o` are low and `ss_discharge_o` is high.
- R4: The first buck start after the supply becomes ready requires enable high, S3 input high and `main5_ok_i` high; until then the block remains in S5.
- R5: During buck soft-start, the buck and the standby 3.3V LDO are on, `ss_charge_o` is high and both gate controls are low, until `ss_lvl_i[0]` (1.5 V) is seen.
- R6: `vtt_en_o` and `ldo12_en_o` rise only in the cycle after `ss_lvl_i[2]` (2.5 V) is high. During the wait, the gate controls are already high and the standby LDO is off.
- R7: In S0, the buck, VTT and 1.2V enables are high, `sb33_en_o` is low, both gate controls are high and `ss_charge_o` is high.
- R8: On S3 input low, the block enters S3: buck and standby LDO on, VTT, 1.2V and both gate controls low. `ss_discharge_o` follows `ss_lvl_i[1]` (2.0 V), so the ramp is pulled down to the 2.0 V level and then held.
- R9: The transition from S3 back to S0 waits for both S3 input high and `main5_ok_i` high.
- R10: Enable low in any running state returns the block to S5. Once the buck has been started since supply-ready, enable high again restarts the buck without needing `main5_ok_i`.
- R11: A fall of `supply_ok_i` returns the block to its power-up state within one cycle and forgets the earlier buck start, so R4 applies again.
- R12: A change on `chip_en_i` or `s3_n_i` changes the outputs after the third rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Bias supply above undervoltage lockout |
| chip_en_i | input | 1 | Chip enable (S5 signal, high = awake), asynchronous |
| s3_n_i | input | 1 | S3 input (low = suspend), asynchronous |
| main5_ok_i | input | 1 | Main 5V rail above its lockout threshold |
| ss_lvl_i | input | 3 | Soft-start above 1.5 V / 2.0 V / 2.5 V (bits 0/1/2) |
| buck_en_o | output | 1 | Memory buck regulator enable |
| vtt_en_o | output | 1 | Termination tracking LDO enable |
| ldo12_en_o | output | 1 | 1.2V LDO enable |
| sb33_en_o | output | 1 | Standby 3.3V LDO enable |
| dual_main_en_o | output | 1 | Gate control for the main-side dual-rail switches (high = main supplies the rails) |
| sb5_gate_o | output | 1 | Gate control for the standby-5V switch (low = standby supplies the dual 5V) |
| ss_charge_o | output | 1 | Soft-start charge command |
| ss_discharge_o | output | 1 | Soft-start discharge command |

## Verification
The hardest situation to reach is the one where the buck has already been started once since supply-ready. Only then does enable alone, without the main-5V flag, restart it, and only a supply drop clears that memory. The bench walks the block through a full S5, S0, S3, S0, S5 cycle with the soft-start flags driven step by step. It then re-enables the block with the main-5V flag low. Next it drops and restores the supply with the S3 input low, to show that the earlier start has been forgotten. A second power cycle measures the ignore and settle window exactly, by counting edges until the buck rises.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  localparam int LVL_W = 3;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_IGNORE = 3'd1,
    ST_SETTLE = 3'd2,
    ST_S5     = 3'd3,
    ST_BUCKSS = 3'd4,
    ST_LDOSS  = 3'd5,
    ST_S0     = 3'd6,
    ST_S3     = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic buck;
    logic vtt;
    logic ldo12;
    logic sb33;
    logic dual_main;
    logic sb5_gate;
    logic ss_chg;
    logic ss_dis;
  } rail_cmd_t;

endpackage

// File: rtl/acpi_sync.sv
module acpi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/acpi_wait_timer.sv
module acpi_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load_i)       cnt <= load_val_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
  assign zero_o = (cnt == '0);
endmodule

// File: rtl/acpi_rail_decode.sv
module acpi_rail_decode
  import acpi_seq_pkg::*;
(
  input  seq_state_e st_i,
  input  logic       ss_above_2v0_i,
  output rail_cmd_t  cmd_o
);
  always_comb begin
    cmd_o = '0;
    unique case (st_i)
      ST_POR:    cmd_o.ss_dis = 1'b1;
      ST_IGNORE,
      ST_SETTLE,
      ST_S5: begin
        cmd_o.sb33   = 1'b1;
        cmd_o.ss_dis = 1'b1;
      end
      ST_BUCKSS: begin
        cmd_o.buck   = 1'b1;
        cmd_o.sb33   = 1'b1;
        cmd_o.ss_chg = 1'b1;
      end
      ST_LDOSS: begin
        cmd_o.buck      = 1'b1;
        cmd_o.dual_main = 1'b1;
        cmd_o.sb5_gate  = 1'b1;
        cmd_o.ss_chg    = 1'b1;
      end
      ST_S0: begin
        cmd_o.buck      = 1'b1;
        cmd_o.vtt       = 1'b1;
        cmd_o.ldo12     = 1'b1;
        cmd_o.dual_main = 1'b1;
        cmd_o.sb5_gate  = 1'b1;
        cmd_o.ss_chg    = 1'b1;
      end
      ST_S3: begin
        cmd_o.buck   = 1'b1;
        cmd_o.sb33   = 1'b1;
        cmd_o.ss_dis = ss_above_2v0_i;
      end
      default: cmd_o.ss_dis = 1'b1;
    endcase
  end
endmodule

// File: rtl/acpi_rail_seq.sv
module acpi_rail_seq
  import acpi_seq_pkg::*;
#(
  parameter int IGNORE_CYC = 2000,
  parameter int SETTLE_CYC = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok_i,
  input  logic             chip_en_i,
  input  logic             s3_n_i,
  input  logic             main5_ok_i,
  input  logic [LVL_W-1:0] ss_lvl_i,
  output logic             buck_en_o,
  output logic             vtt_en_o,
  output logic             ldo12_en_o,
  output logic             sb33_en_o,
  output logic             dual_main_en_o,
  output logic             sb5_gate_o,
  output logic             ss_charge_o,
  output logic             ss_discharge_o
);
  localparam int MAX_CYC = (IGNORE_CYC > SETTLE_CYC) ? IGNORE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e st_q, st_d;
  logic       booted_q;
  logic [1:0] sync_q;
  logic       en_s, awake_s;
  logic       tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  rail_cmd_t  cmd_d, cmd_q;

  acpi_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk (clk), .rst (rst),
    .d_i ({chip_en_i, s3_n_i}),
    .q_o (sync_q)
  );
  assign en_s    = sync_q[1];
  assign awake_s = sync_q[0];

  always_comb begin
    st_d = st_q;
    if (!supply_ok_i) begin
      st_d = ST_POR;
    end else begin
      unique case (st_q)
        ST_POR:    st_d = ST_IGNORE;
        ST_IGNORE: if (tmr_zero) st_d = ST_SETTLE;
        ST_SETTLE: if (tmr_zero) st_d = ST_S5;
        ST_S5:
          if (en_s && (booted_q || (awake_s && main5_ok_i))) st_d = ST_BUCKSS;
        ST_BUCKSS:
          if (!en_s)            st_d = ST_S5;
          else if (ss_lvl_i[0]) st_d = (awake_s && main5_ok_i) ? ST_LDOSS : ST_S3;
        ST_LDOSS:
          if (!en_s)            st_d = ST_S5;
          else if (!awake_s)    st_d = ST_S3;
          else if (ss_lvl_i[2]) st_d = ST_S0;
        ST_S0:
          if (!en_s)            st_d = ST_S5;
          else if (!awake_s)    st_d = ST_S3;
        ST_S3:
          if (!en_s)            st_d = ST_S5;
          else if (awake_s && main5_ok_i) st_d = ST_LDOSS;
        default:                st_d = ST_POR;
      endcase
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st_d == ST_IGNORE && st_q != ST_IGNORE) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(IGNORE_CYC - 1);
    end else if (st_d == ST_SETTLE && st_q != ST_SETTLE) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(SETTLE_CYC - 1);
    end
  end

  acpi_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk (clk), .rst (rst),
    .load_i (tmr_load), .load_val_i (tmr_val),
    .zero_o (tmr_zero)
  );

  acpi_rail_decode u_dec (
    .st_i (st_d), .ss_above_2v0_i (ss_lvl_i[1]), .cmd_o (cmd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_POR;
      booted_q <= 1'b0;
      cmd_q    <= '{ss_dis: 1'b1, default: 1'b0};
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      if (st_d == ST_POR)                         booted_q <= 1'b0;
      else if (st_q == ST_BUCKSS && ss_lvl_i[0])  booted_q <= 1'b1;
    end
  end

  assign buck_en_o      = cmd_q.buck;
  assign vtt_en_o       = cmd_q.vtt;
  assign ldo12_en_o     = cmd_q.ldo12;
  assign sb33_en_o      = cmd_q.sb33;
  assign dual_main_en_o = cmd_q.dual_main;
  assign sb5_gate_o     = cmd_q.sb5_gate;
  assign ss_charge_o    = cmd_q.ss_chg;
  assign ss_discharge_o = cmd_q.ss_dis;
endmodule

// File: rtl/acpi_rail_seq_chk.sv
module acpi_rail_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok_i,
  input logic [2:0] ss_lvl_i,
  input logic       buck_en_o,
  input logic       vtt_en_o,
  input logic       ldo12_en_o,
  input logic       sb33_en_o,
  input logic       dual_main_en_o,
  input logic       ss_charge_o,
  input logic       ss_discharge_o
);
  // R1 / R11: supply loss shuts the rails and drains soft-start next cycle
  assert_supply_loss_R11: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> (!buck_en_o && !vtt_en_o && !ldo12_en_o && ss_discharge_o));

  // R6: LDOs only start after the 2.5 V flag was seen
  assert_ldo_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(vtt_en_o) |-> $past(ss_lvl_i[2]));

  // R6 / R7: termination LDO never without the buck
  assert_vtt_needs_buck_R7: assert property (@(posedge clk) disable iff (rst)
    (vtt_en_o || ldo12_en_o) |-> buck_en_o);

  // R7 / R8: standby LDO and main-side dual switches never on together
  assert_dual_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    dual_main_en_o |-> !sb33_en_o);

  // R5: soft-start never charged and discharged at once
  assert_ss_cmd_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(ss_charge_o && ss_discharge_o));
endmodule

bind acpi_rail_seq acpi_rail_seq_chk u_chk (.*);

// File: tb/tb_acpi_rail_seq.sv
module tb_acpi_rail_seq;
  localparam int IGN = 6;
  localparam int SET = 4;

  logic clk = 1'b0;
  logic rst, supply_ok, chip_en, s3_n, main5_ok;
  logic [2:0] lvl;
  logic buck, vtt, l12, sb33, dmain, sb5, chg, dis;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acpi_rail_seq #(.IGNORE_CYC(IGN), .SETTLE_CYC(SET)) dut (
    .clk (clk), .rst (rst), .supply_ok_i (supply_ok), .chip_en_i (chip_en),
    .s3_n_i (s3_n), .main5_ok_i (main5_ok), .ss_lvl_i (lvl),
    .buck_en_o (buck), .vtt_en_o (vtt), .ldo12_en_o (l12), .sb33_en_o (sb33),
    .dual_main_en_o (dmain), .sb5_gate_o (sb5), .ss_charge_o (chg),
    .ss_discharge_o (dis)
  );

  // expected vectors {buck,vtt,l12,sb33,dmain,sb5,chg,dis}
  localparam logic [7:0] V_POR   = 8'b0000_0001;
  localparam logic [7:0] V_S5    = 8'b0001_0001;
  localparam logic [7:0] V_BUCK  = 8'b1001_0010;
  localparam logic [7:0] V_LDO   = 8'b1000_1110;
  localparam logic [7:0] V_S0    = 8'b1110_1110;
  localparam logic [7:0] V_S3DIS = 8'b1001_0001;
  localparam logic [7:0] V_S3HLD = 8'b1001_0000;

  function automatic logic [7:0] outs();
    return {buck, vtt, l12, sb33, dmain, sb5, chg, dis};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, outs(), exp);
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1; supply_ok = 0; chip_en = 1; s3_n = 1; main5_ok = 0; lvl = 3'b000;
    step(3);
    chk("R1 reset", V_POR);
    rst = 0;
    step(3);
    chk("R1 supply low", V_POR);

    // first power-up with main 5V low: must stay in S5
    supply_ok = 1;
    step(IGN + SET + 20);
    chk("R4 no main5 stays S5", V_S5);
    chk("R3 S5 table", V_S5);
    main5_ok = 1;
    step(1);
    chk("R5 buck soft-start", V_BUCK);
    step(5);
    chk("R5 waits for 1.5V", V_BUCK);
    lvl = 3'b001;
    step(1);
    chk("R6 LDO wait table", V_LDO);
    lvl = 3'b011;
    step(4);
    chk("R6 no LDO below 2.5V", V_LDO);
    lvl = 3'b111;
    step(1);
    chk("R7 S0 table", V_S0);

    // S0 -> S3 through the synchroniser
    s3_n = 0;
    step(2);
    chk("R12 s3 not yet seen", V_S0);
    step(1);
    chk("R8 S3 discharging to 2V", V_S3DIS);
    lvl = 3'b001;
    step(1);
    chk("R8 S3 hold below 2V", V_S3HLD);

    // S3 -> S0 requires main 5V
    main5_ok = 0; s3_n = 1;
    step(8);
    chk("R9 no main5 stays S3", V_S3HLD);
    main5_ok = 1;
    step(1);
    chk("R9 resume LDO wait", V_LDO);
    lvl = 3'b111;
    step(1);
    chk("R9 back in S0", V_S0);

    // enable low -> S5, then restart without main 5V
    chip_en = 0;
    step(2);
    chk("R12 enable not yet seen", V_S0);
    step(1);
    chk("R10 enable low gives S5", V_S5);
    main5_ok = 0; lvl = 3'b000;
    chip_en = 1;
    step(3);
    chk("R10 restart after boot", V_BUCK);
    lvl = 3'b001;
    step(1);
    chk("R10 no main5 goes S3", V_S3HLD);

    // power cycle: exact ignore + settle window
    supply_ok = 0; lvl = 3'b000; main5_ok = 1;
    step(1);
    chk("R11 supply loss", V_POR);
    supply_ok = 1;
    for (int k = 1; k <= IGN + SET + 1; k++) begin
      step(1);
      chk($sformatf("R2 window cycle %0d", k), V_S5);
    end
    step(1);
    chk("R2 buck after window", V_BUCK);

    // power cycle with S3 low: earlier start must be forgotten
    supply_ok = 0;
    step(1);
    s3_n = 0; supply_ok = 1;
    step(IGN + SET + 10);
    chk("R11 boot memory cleared", V_S5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule